// File: doc/BRIEF.md
# Memory Operand Offset Unit

This unit forms the 16-bit offset of a memory operand and picks the segment that the operand belongs to by default. Each request carries an addressing-form code, fields naming the base register and the index register that the form uses, a displacement-size code, the current contents of the two base registers and the two index registers, and a displacement word. One clock edge later the unit returns the offset, a flag that selects the stack segment instead of the data segment, and a flag that marks a register combination the forms do not allow.

The unit accepts a request in any cycle that `in_valid` is high. `out_valid` rises one cycle after the request. Its results stay unchanged while no request is offered. Its output goes straight into the adder that combines segment and offset. Segment override prefixes are applied downstream and are not handled here.

Top module: `ea_offset_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output clears at that edge: `out_valid`, `offset`, `seg_ss` and `invalid` are all 0.
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low otherwise. A cycle with `in_valid` low leaves `offset`, `seg_ss` and `invalid` unchanged.
- R3: The form code `mode` is 0 for direct, 1 for register-indirect, 2 for indexed, 3 for based and 4 for based-indexed. Codes 5 to 7 are invalid. `base_code` is 0 for none, 1 for BX, 2 for BP and 3 reserved. `idx_code` is 0 for none, 1 for SI, 2 for DI and 3 reserved. `disp_kind` is 0 for none, 1 for 8-bit, 2 for 16-bit and 3 reserved. A direct request has no base, no index and a 16-bit displacement. Its offset is `disp`, with `seg_ss` = 0.
- R4: A register-indirect request names exactly one register, which is BX, SI or DI, and has no displacement. Its offset is that register's content, with `seg_ss` = 0.
- R5: An indexed request names SI or DI, has no base, and has an 8-bit or 16-bit displacement. Its offset is the index plus the displacement, with `seg_ss` = 0.
- R6: A based request names BX or BP, has no index, and has an 8-bit or 16-bit displacement. Its offset is the base plus the displacement. `seg_ss` is 1 exactly when the base is BP.
- R7: A based-indexed request names BX or BP and SI or DI, and has no displacement. Its offset is the base plus the index. `seg_ss` is 1 exactly when the base is BP.
- R8: With `disp_kind` = 1, only `disp[7:0]` is used. It is sign-extended to 16 bits, so `disp[15:8]` has no effect on the result.
- R9: Every offset sum wraps modulo 2^16.
- R10: Any other combination of `mode`, `base_code`, `idx_code` and `disp_kind` yields `invalid` = 1, `offset` = 0 and `seg_ss` = 0. Valid requests yield `invalid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-form code |
| base_code | input | 2 | Base register field |
| idx_code | input | 2 | Index register field |
| disp_kind | input | 2 | Displacement size code |
| reg_bx | input | 16 | BX content |
| reg_bp | input | 16 | BP content |
| reg_si | input | 16 | SI content |
| reg_di | input | 16 | DI content |
| disp | input | 16 | Displacement word |
| out_valid | output | 1 | Result present |
| offset | output | 16 | Operand offset |
| seg_ss | output | 1 | 1 selects the stack segment, 0 the data segment |
| invalid | output | 1 | Disallowed combination |

## Verification
Sign extension of a short displacement and the modulo-2^16 wrap can occur in one addition. For example, a negative 8-bit displacement added to a small index lands below zero, and a large base added to an index crosses 0xFFFF. The sweep sets up these cases by running every code combination against register values placed near the top of the range, and against displacement words whose upper byte is nonzero while the low byte is negative. Each result is judged against a sum formed in wide arithmetic from the extended displacement and then truncated to 16 bits. A result that ignored the upper-byte rule or kept a carry shows up as a mismatch. The BP-selects-stack rule is judged in the same sweep, both on valid BP forms and on invalid ones such as BP alone in register-indirect form.

// File: rtl/ea_offset_pkg.sv
// Package: codes shared by the offset unit and its parts.
// Assumes the field encodings listed in the brief; values outside an
// enumerated set reach the decoder through casts and are rejected there.
package ea_offset_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_REGIND  = 3'd1,
        AM_INDEXED = 3'd2,
        AM_BASED   = 3'd3,
        AM_BASEIDX = 3'd4
    } am_e;

    typedef enum logic [1:0] {
        BS_NONE = 2'd0,
        BS_BX   = 2'd1,
        BS_BP   = 2'd2,
        BS_RSV  = 2'd3
    } base_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_SI   = 2'd1,
        IX_DI   = 2'd2,
        IX_RSV  = 2'd3
    } idx_e;

    typedef enum logic [1:0] {
        DK_NONE  = 2'd0,
        DK_SHORT = 2'd1,
        DK_WIDE  = 2'd2,
        DK_RSV   = 2'd3
    } dk_e;

    // Operand selection handed from the decoder to the adder.
    typedef struct packed {
        logic ok;
        logic use_base;
        logic base_bp;
        logic use_idx;
        logic idx_di;
        dk_e  dk;
    } sel_t;

endpackage

// File: rtl/ea_form_decode.sv
// Form decoder: checks that the register and displacement fields fit the
// requested addressing form, and turns them into operand selects.
// Assumes nothing about the operand values; purely combinational.
module ea_form_decode
    import ea_offset_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] base_code,
    input  logic [1:0] idx_code,
    input  logic [1:0] disp_kind,
    output sel_t       sel
);

    am_e   am;
    base_e bs;
    idx_e  ix;
    dk_e   dk;
    logic  has_base, has_idx, has_disp;

    // Interpret the raw fields as typed codes.
    always_comb begin
        am = am_e'(mode);
        bs = base_e'(base_code);
        ix = idx_e'(idx_code);
        dk = dk_e'(disp_kind);
        has_base = (bs == BS_BX) || (bs == BS_BP);
        has_idx  = (ix == IX_SI) || (ix == IX_DI);
        has_disp = (dk == DK_SHORT) || (dk == DK_WIDE);
    end

    // Decide whether the field combination is an allowed pairing for the form.
    always_comb begin
        sel.ok = 1'b0;
        case (am)
            AM_DIRECT:  sel.ok = (bs == BS_NONE) && (ix == IX_NONE) && (dk == DK_WIDE);
            AM_REGIND:  sel.ok = (dk == DK_NONE) &&
                                 (((bs == BS_BX) && (ix == IX_NONE)) ||
                                  ((bs == BS_NONE) && has_idx));
            AM_INDEXED: sel.ok = (bs == BS_NONE) && has_idx && has_disp;
            AM_BASED:   sel.ok = has_base && (ix == IX_NONE) && has_disp;
            AM_BASEIDX: sel.ok = has_base && has_idx && (dk == DK_NONE);
            default:    sel.ok = 1'b0;
        endcase
        sel.use_base = has_base;
        sel.base_bp  = (bs == BS_BP);
        sel.use_idx  = has_idx;
        sel.idx_di   = (ix == IX_DI);
        sel.dk       = dk;
    end

endmodule

// File: rtl/ea_offset_adder.sv
// Offset adder: forms base + index + displacement from the selects, each
// term zero when unused; the short displacement is sign-extended.
// Assumes SHORT_W does not exceed WORD_W; the sum wraps at WORD_W bits.
module ea_offset_adder
    import ea_offset_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  sel_t              sel,
    input  logic [WORD_W-1:0] reg_bx,
    input  logic [WORD_W-1:0] reg_bp,
    input  logic [WORD_W-1:0] reg_si,
    input  logic [WORD_W-1:0] reg_di,
    input  logic [WORD_W-1:0] disp,
    output logic [WORD_W-1:0] sum
);

    localparam int EXT_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] short_ext;
    logic [WORD_W-1:0] base_term, idx_term, disp_term;

    // Widen the short displacement by copying its sign bit.
    generate
        if (EXT_W > 0) begin : g_ext
            assign short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_noext
            assign short_ext = disp;
        end
    endgenerate

    // Pick each term of the sum from the operand selects.
    always_comb begin
        base_term = '0;
        if (sel.use_base) base_term = sel.base_bp ? reg_bp : reg_bx;
        idx_term = '0;
        if (sel.use_idx) idx_term = sel.idx_di ? reg_di : reg_si;
        case (sel.dk)
            DK_SHORT: disp_term = short_ext;
            DK_WIDE:  disp_term = disp;
            default:  disp_term = '0;
        endcase
        sum = base_term + idx_term + disp_term;
    end

endmodule

// File: rtl/ea_offset_unit.sv
// Top: decodes the addressing form, sums the chosen operands, and registers
// offset, segment choice and invalid flag one cycle after each request.
// Assumes operand registers are stable in the request cycle; holds results
// while idle.
module ea_offset_unit
    import ea_offset_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [1:0]        base_code,
    input  logic [1:0]        idx_code,
    input  logic [1:0]        disp_kind,
    input  logic [WORD_W-1:0] reg_bx,
    input  logic [WORD_W-1:0] reg_bp,
    input  logic [WORD_W-1:0] reg_si,
    input  logic [WORD_W-1:0] reg_di,
    input  logic [WORD_W-1:0] disp,
    output logic              out_valid,
    output logic [WORD_W-1:0] offset,
    output logic              seg_ss,
    output logic              invalid
);

    sel_t              sel;
    logic [WORD_W-1:0] sum;

    ea_form_decode u_decode (
        .mode      (mode),
        .base_code (base_code),
        .idx_code  (idx_code),
        .disp_kind (disp_kind),
        .sel       (sel)
    );

    ea_offset_adder #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_adder (
        .sel    (sel),
        .reg_bx (reg_bx),
        .reg_bp (reg_bp),
        .reg_si (reg_si),
        .reg_di (reg_di),
        .disp   (disp),
        .sum    (sum)
    );

    // Track whether a result is being presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result of an accepted request; squash disallowed ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset  <= '0;
            seg_ss  <= 1'b0;
            invalid <= 1'b0;
        end else if (in_valid) begin
            offset  <= sel.ok ? sum : '0;
            seg_ss  <= sel.ok && sel.base_bp;
            invalid <= !sel.ok;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(offset) && $stable(seg_ss) && $stable(invalid)));
    a_r10_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> (offset == '0 && !seg_ss));
    a_r3_direct_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0 && base_code == 2'd0 && idx_code == 2'd0 &&
         disp_kind == 2'd2) |=> (offset == $past(disp) && !seg_ss && !invalid));
    a_r7_bp_pair_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd4 && base_code == 2'd2 &&
         (idx_code == 2'd1 || idx_code == 2'd2) && disp_kind == 2'd0)
        |=> (seg_ss && !invalid));

endmodule

// File: tb/ea_offset_unit_bench.sv
// Bench: sweeps every code combination against four operand sets and
// compares against wide arithmetic truncated to 16 bits.
module ea_offset_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  base_code = '0, idx_code = '0, disp_kind = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, disp = '0;
    logic        out_valid, seg_ss, invalid;
    logic [15:0] offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ea_offset_unit u_ea_offset_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .base_code(base_code), .idx_code(idx_code), .disp_kind(disp_kind),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .disp(disp), .out_valid(out_valid), .offset(offset),
        .seg_ss(seg_ss), .invalid(invalid)
    );

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {valid,ss,inv,off}=%h expected %h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements: returns {ss,inv,off} and a tag.
    task automatic model(output logic [17:0] res, output string tag);
        logic        okb, bpb;
        logic [31:0] s;
        logic [15:0] d;
        d = (disp_kind == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : disp;
        s = 0; okb = 0; bpb = (base_code == 2'd2);
        case (mode)
            3'd0: begin okb = base_code == 0 && idx_code == 0 && disp_kind == 2; s = disp; tag = "R3"; end
            3'd1: begin
                okb = disp_kind == 0 && ((base_code == 1 && idx_code == 0) ||
                      (base_code == 0 && (idx_code == 1 || idx_code == 2)));
                s = (base_code == 1) ? reg_bx : (idx_code == 1 ? reg_si : reg_di);
                tag = "R4";
            end
            3'd2: begin
                okb = base_code == 0 && (idx_code == 1 || idx_code == 2) &&
                      (disp_kind == 1 || disp_kind == 2);
                s = 32'(idx_code == 1 ? reg_si : reg_di) + 32'(d); tag = "R5";
            end
            3'd3: begin
                okb = (base_code == 1 || base_code == 2) && idx_code == 0 &&
                      (disp_kind == 1 || disp_kind == 2);
                s = 32'(bpb ? reg_bp : reg_bx) + 32'(d); tag = "R6";
            end
            3'd4: begin
                okb = (base_code == 1 || base_code == 2) &&
                      (idx_code == 1 || idx_code == 2) && disp_kind == 0;
                s = 32'(bpb ? reg_bp : reg_bx) + 32'(idx_code == 1 ? reg_si : reg_di);
                tag = "R7";
            end
            default: begin okb = 0; tag = "R10"; end
        endcase
        if (!okb) begin
            res = {1'b0, 1'b1, 16'h0}; tag = "R10";
        end else begin
            res = {bpb, 1'b0, s[15:0]};
            if (s[31:16] != 0 && mode != 3'd0) tag = "R9";
            else if (disp_kind == 2'd1) tag = "R8";
        end
    endtask

    task automatic load_set(input int v);
        case (v)
            0: begin reg_bx = 16'h1200; reg_bp = 16'h3400; reg_si = 16'h0056; reg_di = 16'h0078; disp = 16'h0123; end
            1: begin reg_bx = 16'hFFF0; reg_bp = 16'hFF00; reg_si = 16'h0020; reg_di = 16'h0100; disp = 16'hAB85; end
            2: begin reg_bx = 16'h0005; reg_bp = 16'h0002; reg_si = 16'h0010; reg_di = 16'h0001; disp = 16'h7F80; end
            default: begin reg_bx = 16'h8000; reg_bp = 16'h8001; reg_si = 16'h8000; reg_di = 16'hFFFF; disp = 16'hFFFF; end
        endcase
    endtask

    initial begin
        logic [17:0] exp;
        logic [18:0] held;
        string tag;
        repeat (3) @(negedge clk);
        check("R1", {out_valid, seg_ss, invalid, offset}, 19'h0);
        rst_n = 1'b1;
        for (int v = 0; v < 4; v++) begin
            load_set(v);
            for (int c = 0; c < 512; c++) begin
                @(negedge clk);
                {mode, base_code, idx_code, disp_kind} = 9'(c);
                in_valid = 1'b1;
                model(exp, tag);
                @(negedge clk);
                in_valid = 1'b0;
                check(tag, {out_valid, seg_ss, invalid, offset}, {1'b1, exp});
            end
        end
        // R8: upper displacement byte ignored for short displacements.
        load_set(0);
        for (int hi = 0; hi < 256; hi += 51) begin
            @(negedge clk);
            mode = 3'd2; base_code = 0; idx_code = 1; disp_kind = 1;
            disp = {8'(hi), 8'hF0}; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R8", {out_valid, seg_ss, invalid, offset}, {3'b100, 16'h0046});
        end
        // R2: idle cycles drop out_valid and keep the last result.
        @(negedge clk);
        held = {1'b0, seg_ss, invalid, offset};
        mode = 3'd3; base_code = 2; idx_code = 0; disp_kind = 2; reg_bp = 16'h4444;
        repeat (3) begin
            @(negedge clk);
            check("R2", {out_valid, seg_ss, invalid, offset}, held);
        end
        // R1: reset in mid-operation clears outputs.
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, seg_ss, invalid, offset}, 19'h0);
        in_valid = 1'b0; rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule